// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 64-bit fetch address and works out, every cycle, where the following fetch goes. A control-kind selector picks one of four sources: the plain sequential step, a conditional branch whose taken or not-taken outcome is supplied by another block, a jump that replaces the low 28 bits of the address while staying inside the current 256 MB region, and a jump to an address held in a general register. The chosen address is shown on `pc_nxt` in the same cycle and loaded into the program counter at the next clock edge when `advance` is high.

Register-sourced targets can carry a bad alignment. When this happens, the block raises `misalign` and keeps the current program counter. A trap handler outside this block can then take over. Condition evaluation, delay slots and prediction are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and until the first advancing edge after it goes high, `pc_q` equals the parameter `RESET_VEC`.
- R2: With `ctl_kind` = 2'b00 (sequential), `pc_nxt` equals `pc_q` + 4.
- R3: With `ctl_kind` = 2'b01 and `br_taken` = 1, `pc_nxt` equals `pc_q` + 4 + 4 × sign-extended `br_ofs` (bit 15 is the sign).
- R4: With `ctl_kind` = 2'b01 and `br_taken` = 0, `pc_nxt` equals `pc_q` + 4, whatever `br_ofs` holds.
- R5: With `ctl_kind` = 2'b10, `pc_nxt` is formed from three parts. Bits 63..28 are those bits of `pc_q` + 4. Bits 27..2 are `jmp_idx`. Bits 1..0 are zero.
- R6: With `ctl_kind` = 2'b11, `pc_nxt` equals `reg_tgt`.
- R7: `misalign` is high exactly when `ctl_kind` = 2'b11 and `reg_tgt` bits 1..0 are not both zero. On such a cycle `pc_q` does not change.
- R8: When `advance` is low, `pc_q` keeps its value at the clock edge.
- R9: When `advance` is high and `misalign` is low, `pc_q` takes the value `pc_nxt` showed in the cycle before the edge.
- R10: All address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Clock enable for the program counter |
| ctl_kind | input | 2 | 00 sequential, 01 branch, 10 region jump, 11 register jump |
| br_taken | input | 1 | Branch condition outcome |
| br_ofs | input | 16 | Signed word offset for branches |
| jmp_idx | input | 26 | Word index for region jumps |
| reg_tgt | input | 64 | Register-held jump target |
| pc_q | output | 64 | Current program counter |
| pc_nxt | output | 64 | Address selected for the next fetch |
| misalign | output | 1 | Register target is not word aligned |

## Verification
The bench builds the unit at the default widths (64-bit address, 16-bit offset, 26-bit index, 4-byte instructions) and overrides `RESET_VEC` with a value other than zero, so that the reset check is able to tell the vector apart from a cleared register. With full 64-bit width, the most negative offset reaches sign extension across the top bits. A counter just below a 256 MB boundary shows that the region is taken from the incremented address. An all-ones counter makes the sequential step wrap to zero.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'b00,
    NPC_BRANCH = 2'b01,
    NPC_REGION = 2'b10,
    NPC_REGJMP = 2'b11
  } npc_kind_e;
endpackage

// File: rtl/npc_incr.sv
// Sequential step: adds one instruction size to the current address.
module npc_incr #(
  parameter int PC_W       = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic [PC_W-1:0] pc_cur,
  output logic [PC_W-1:0] pc_step
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  always_comb begin
    pc_step = pc_cur + STEP;
  end
endmodule

// File: rtl/npc_branch_tgt.sv
// Branch target: stepped address plus the sign-extended, word-scaled offset.
module npc_branch_tgt #(
  parameter int PC_W       = 64,
  parameter int OFS_W      = 16,
  parameter int ALIGN_BITS = 2
) (
  input  logic [PC_W-1:0]  pc_step,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  br_tgt
);
  localparam int EXT_W = PC_W - OFS_W - ALIGN_BITS;

  logic [PC_W-1:0] ofs_scaled;

  always_comb begin
    ofs_scaled = {{EXT_W{ofs[OFS_W-1]}}, ofs, {ALIGN_BITS{1'b0}}};
    br_tgt     = pc_step + ofs_scaled;
  end
endmodule

// File: rtl/npc_region_tgt.sv
// Region jump: keeps the upper bits of the stepped address, splices the index.
module npc_region_tgt #(
  parameter int PC_W       = 64,
  parameter int IDX_W      = 26,
  parameter int ALIGN_BITS = 2
) (
  input  logic [PC_W-IDX_W-ALIGN_BITS-1:0] region_hi,
  input  logic [IDX_W-1:0]                 idx,
  output logic [PC_W-1:0]                  rg_tgt
);
  always_comb begin
    rg_tgt = {region_hi, idx, {ALIGN_BITS{1'b0}}};
  end
endmodule

// File: rtl/npc_select.sv
// Source selection and register-target alignment check.
module npc_select
  import npc_pkg::*;
#(
  parameter int PC_W       = 64,
  parameter int ALIGN_BITS = 2
) (
  input  npc_kind_e       kind,
  input  logic            taken,
  input  logic [PC_W-1:0] pc_step,
  input  logic [PC_W-1:0] br_tgt,
  input  logic [PC_W-1:0] rg_tgt,
  input  logic [PC_W-1:0] reg_tgt,
  output logic [PC_W-1:0] pc_sel,
  output logic            bad_align
);
  always_comb begin
    pc_sel    = pc_step;
    bad_align = 1'b0;
    unique case (kind)
      NPC_SEQ:    pc_sel = pc_step;
      NPC_BRANCH: pc_sel = taken ? br_tgt : pc_step;
      NPC_REGION: pc_sel = rg_tgt;
      NPC_REGJMP: begin
        pc_sel    = reg_tgt;
        bad_align = |reg_tgt[ALIGN_BITS-1:0];
      end
      default:    pc_sel = pc_step;
    endcase
  end

  // R7: only a register jump can be flagged
  always_comb begin
    if (bad_align) begin
      a_flag_only_regjump_r7: assert (kind == NPC_REGJMP);
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              PC_W       = 64,
  parameter int              OFS_W      = 16,
  parameter int              IDX_W      = 26,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_VEC  = 64'h0000_0000_0001_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [1:0]       ctl_kind,
  input  logic             br_taken,
  input  logic [OFS_W-1:0] br_ofs,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic [PC_W-1:0]  reg_tgt,
  output logic [PC_W-1:0]  pc_q,
  output logic [PC_W-1:0]  pc_nxt,
  output logic             misalign
);
  localparam int ALIGN_BITS = $clog2(INSN_BYTES);
  localparam int REGION_LO  = IDX_W + ALIGN_BITS;
  localparam int HI_W       = PC_W - REGION_LO;

  npc_kind_e       kind;
  logic [PC_W-1:0] pc_step;
  logic [PC_W-1:0] br_tgt;
  logic [PC_W-1:0] rg_tgt;
  logic [PC_W-1:0] pc_d;
  logic            load_en;

  always_comb begin
    kind = npc_kind_e'(ctl_kind);
  end

  npc_incr #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_incr (
    .pc_cur  (pc_q),
    .pc_step (pc_step)
  );

  npc_branch_tgt #(.PC_W(PC_W), .OFS_W(OFS_W), .ALIGN_BITS(ALIGN_BITS)) u_br (
    .pc_step (pc_step),
    .ofs     (br_ofs),
    .br_tgt  (br_tgt)
  );

  npc_region_tgt #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_rg (
    .region_hi (pc_step[PC_W-1 -: HI_W]),
    .idx       (jmp_idx),
    .rg_tgt    (rg_tgt)
  );

  npc_select #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS)) u_sel (
    .kind      (kind),
    .taken     (br_taken),
    .pc_step   (pc_step),
    .br_tgt    (br_tgt),
    .rg_tgt    (rg_tgt),
    .reg_tgt   (reg_tgt),
    .pc_sel    (pc_nxt),
    .bad_align (misalign)
  );

  // next-state: load only when enabled and the target is usable
  always_comb begin
    load_en = advance & ~misalign;
    pc_d    = load_en ? pc_nxt : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_VEC;
    end else begin
      pc_q <= pc_d;
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc_q));

  p_misalign_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> $stable(pc_q));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ctl_kind == 2'b00) |=> (pc_q == $past(pc_q) + PC_W'(INSN_BYTES)));

  p_load_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !misalign) |=> (pc_q == $past(pc_nxt)));

  p_region_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ctl_kind == 2'b10) |=>
      (pc_q[PC_W-1 -: HI_W] == $past(pc_step[PC_W-1 -: HI_W])));
endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
  localparam logic [63:0] RV = 64'h0000_0000_0000_2000;
  localparam int NV = 9;

  // start pc, kind, taken, offset, index, register value, expected next
  localparam logic [63:0] V_PC [NV] = '{
    64'h0000_0000_0000_1000, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_1000,
    64'h0000_0000_0000_1000, 64'h0000_0000_0000_1000, 64'h1234_5678_9ABC_D000,
    64'h0000_0000_0FFF_FFFC, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFC};
  localparam logic [1:0]  V_K  [NV] = '{2'b00, 2'b01, 2'b01, 2'b01, 2'b01,
                                        2'b10, 2'b10, 2'b11, 2'b00};
  localparam logic        V_T  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                                        1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [15:0] V_O  [NV] = '{16'h0000, 16'h0010, 16'hFFFF, 16'h0100,
                                        16'h8000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [25:0] V_I  [NV] = '{26'h0, 26'h0, 26'h0, 26'h0, 26'h0,
                                        26'h3FF_FFFF, 26'h10, 26'h0, 26'h0};
  localparam logic [63:0] V_R  [NV] = '{64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
                                        64'h0, 64'h0, 64'hDEAD_BEEF_0000_0100, 64'h0};
  localparam logic [63:0] V_E  [NV] = '{
    64'h0000_0000_0000_1004, 64'h0000_0000_0000_1044, 64'h0000_0000_0000_1000,
    64'h0000_0000_0000_1004, 64'hFFFF_FFFF_FFFE_1004, 64'h1234_5678_9FFF_FFFC,
    64'h0000_0000_1000_0040, 64'hDEAD_BEEF_0000_0100, 64'h0000_0000_0000_0000};
  localparam string V_REQ [NV] = '{"R2", "R3", "R3", "R4", "R3", "R5", "R5", "R6", "R10"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        advance;
  logic [1:0]  ctl_kind;
  logic        br_taken;
  logic [15:0] br_ofs;
  logic [25:0] jmp_idx;
  logic [63:0] reg_tgt;
  logic [63:0] pc_q;
  logic [63:0] pc_nxt;
  logic        misalign;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) dut_i (
    .clk(clk), .rst_n(rst_n), .advance(advance), .ctl_kind(ctl_kind),
    .br_taken(br_taken), .br_ofs(br_ofs), .jmp_idx(jmp_idx), .reg_tgt(reg_tgt),
    .pc_q(pc_q), .pc_nxt(pc_nxt), .misalign(misalign)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic adv, input logic [1:0] k, input logic t,
                       input logic [15:0] o, input logic [25:0] i, input logic [63:0] r);
    advance = adv; ctl_kind = k; br_taken = t; br_ofs = o; jmp_idx = i; reg_tgt = r;
  endtask

  // set pc_q through an aligned register jump
  task automatic load_pc(input logic [63:0] v);
    @(negedge clk);
    drive(1'b1, 2'b11, 1'b0, 16'h0, 26'h0, v);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 2'b00, 1'b0, 16'h0, 26'h0, 64'h0);
    #20;
    chk("R1 in reset", pc_q, RV);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pc_q, RV);

    for (int n = 0; n < NV; n++) begin
      load_pc(V_PC[n]);
      drive(1'b1, V_K[n], V_T[n], V_O[n], V_I[n], V_R[n]);
      #1;
      chk({V_REQ[n], " pc_nxt"}, pc_nxt, V_E[n]);
      chk("R7 flag low", {63'h0, misalign}, 64'h0);
      @(negedge clk);
      chk({V_REQ[n], " R9 loaded"}, pc_q, V_E[n]);
    end

    // R4: not-taken branch ignores a large negative offset
    load_pc(64'h0000_0000_0000_4000);
    drive(1'b1, 2'b01, 1'b0, 16'h8000, 26'h0, 64'h0);
    #1 chk("R4 offset ignored", pc_nxt, 64'h0000_0000_0000_4004);

    // R8: advance low holds the counter
    load_pc(64'h0000_0000_0000_5000);
    drive(1'b0, 2'b00, 1'b0, 16'h0, 26'h0, 64'h0);
    @(negedge clk);
    @(negedge clk);
    chk("R8 hold", pc_q, 64'h0000_0000_0000_5000);

    // R7: misaligned register targets flag and hold
    drive(1'b1, 2'b11, 1'b0, 16'h0, 26'h0, 64'h0000_0000_0000_6002);
    #1 chk("R7 flag high", {63'h0, misalign}, 64'h1);
    @(negedge clk);
    chk("R7 pc kept", pc_q, 64'h0000_0000_0000_5000);
    drive(1'b1, 2'b11, 1'b0, 16'h0, 26'h0, 64'h0000_0000_0000_6001);
    #1 chk("R7 flag bit0", {63'h0, misalign}, 64'h1);
    drive(1'b1, 2'b10, 1'b0, 16'h0, 26'h3, 64'h0000_0000_0000_6003);
    #1 chk("R7 no flag for region jump", {63'h0, misalign}, 64'h0);

    // R1: reset mid-run restores the vector
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async reset", pc_q, RV);
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule